// File: doc/BRIEF.md
# Peripheral Access Ordering Stage

This stage sits between a pipelined processor core and its bus. The core may fetch source operands for a later instruction before an earlier instruction's results have been written. For ordinary memory this is harmless. For peripherals whose registers change when they are read, or that depend on a prior control write, it is not. Writes enter a small first-in first-out queue and drain to the bus in arrival order. Reads are classified by address and by whether their instruction has reached execution. Each read is then either sent at once, held back, or sent as a probe cycle with an active-low inhibit output.

Addresses whose top byte is all ones form a fixed peripheral window. Reads there wait until every queued write has drained and the instruction is executing. Reads outside the window may bypass queued writes to other words. If such a read goes out while it is still unsafe, the inhibit output is driven low. External decoding answers with an active-low decode input. A decoded hit cancels the probe. The read is then reissued, uninhibited, once the queue is empty and the instruction is executing. External select logic must keep the device deselected while the inhibit output is low.

Top module: `mmio_order_unit`

## Requirements
- R1: After reset, the write queue is empty, wr_ready is 1, bus_wr_valid, bus_rd_valid and rd_done are 0, and io_inhibit_n is 1.
- R2: An address lies in the peripheral window exactly when (addr & 0xFF000000) == 0xFF000000, so 0xFF000000 is inside and 0xFEFFFFFC is outside.
- R3: The write queue holds 4 entries. wr_ready is 0 while it is full, and a push offered while full is dropped. Queued writes appear on bus_wr_addr/bus_wr_data in arrival order, and one leaves on each cycle in which bus_wr_valid and bus_wr_ready are both 1.
- R4: A read in the window starts a bus cycle only when the queue is empty and rd_exec is 1. Its bus cycle always has io_inhibit_n at 1.
- R5: A read outside the window whose word (addr[31:2]) matches no queued write starts its bus cycle at once, even with writes queued. io_inhibit_n is 0 in that cycle if the queue was non-empty or rd_exec was 0 at acceptance.
- R6: A read outside the window whose word matches a queued write waits until that write has left the queue.
- R7: An inhibited bus cycle during which io_decode_n is 0 is cancelled, with no rd_done. The read is reissued with io_inhibit_n at 1 only after the queue is empty and rd_exec is 1.
- R8: An inhibited bus cycle during which io_decode_n is 1 completes, with rd_done at 1.
- R9: bus_wr_valid is 0 in every cycle in which bus_rd_valid is 1.
- R10: io_inhibit_n is 0 only in cycles in which bus_rd_valid is 1.
- R11: A read accepted at a clock edge has its bus cycle in the next cycle. The bus cycle lasts one cycle, and rd_done, when given, is in that same cycle. rd_valid and rd_addr are held until rd_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request from the core |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | DATA_W | Write data |
| wr_ready | output | 1 | Queue can accept a write |
| bus_wr_valid | output | 1 | Queue head offered to the bus |
| bus_wr_addr | output | 32 | Address of the head write |
| bus_wr_data | output | DATA_W | Data of the head write |
| bus_wr_ready | input | 1 | Bus takes the head write this cycle |
| rd_valid | input | 1 | Read request, held until rd_done |
| rd_addr | input | 32 | Read byte address |
| rd_exec | input | 1 | Read's instruction is executing and all older writes are queued |
| rd_done | output | 1 | Read bus cycle completed |
| bus_rd_valid | output | 1 | Read bus cycle active |
| bus_rd_addr | output | 32 | Read bus cycle address |
| io_inhibit_n | output | 1 | Active-low inhibit for the current read cycle |
| io_decode_n | input | 1 | Active-low external decode of a side-effect peripheral |

## Verification
On every cycle, the assertions check four things: the queue's occupancy against its valid bits, that the inhibit only accompanies a read cycle, that window reads are never inhibited and always follow an empty queue with an executing instruction, and that no write drains during a read cycle. Some behaviours can only be shown by the bench's scenarios, which sweep queue fill, execute state, decode answer and address class. These are the exact cycle in which each read issues, the arrival order of drained writes, a cancelled probe's later uninhibited retry, and a full queue dropping an extra push.

// File: rtl/mmio_ord_pkg.sv
package mmio_ord_pkg;

  localparam int ADDR_W   = 32;
  localparam int WORD_LSB = 2;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_CYCLE = 2'd1,
    RS_RETRY = 2'd2
  } rd_state_e;

  // peripheral window test: masked bits equal the base
  function automatic logic in_io_window(addr_t a, addr_t base, addr_t mask);
    return (a & mask) == (base & mask);
  endfunction

  // two byte addresses name the same bus word
  function automatic logic same_word(addr_t a, addr_t b);
    return a[ADDR_W-1:WORD_LSB] == b[ADDR_W-1:WORD_LSB];
  endfunction

endpackage

// File: rtl/mmio_wr_queue.sv
module mmio_wr_queue
  import mmio_ord_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  addr_t             push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  addr_t             probe_addr,
  output logic              full,
  output logic              empty,
  output logic              probe_hit,
  output addr_t             head_addr,
  output logic [DATA_W-1:0] head_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  addr_t             a_q [DEPTH];
  logic [DATA_W-1:0] d_q [DEPTH];
  logic [DEPTH-1:0]  vld_vec;
  logic [DEPTH-1:0]  hit_vec;
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;

  // named events for the assertions
  logic ev_accept, ev_take;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt_q == FULL_CNT);
  assign empty     = (cnt_q == '0);
  assign ev_accept = push && !full;
  assign ev_take   = pop && !empty;
  assign head_addr = a_q[rp_q];
  assign head_data = d_q[rp_q];
  assign probe_hit = |hit_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic vld_q;
    localparam logic [PW-1:0] IDX = PW'(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        a_q[i] <= '0;
        d_q[i] <= '0;
      end else begin
        if (ev_take && rp_q == IDX) vld_q <= 1'b0;
        if (ev_accept && wp_q == IDX) begin
          vld_q  <= 1'b1;
          a_q[i] <= push_addr;
          d_q[i] <= push_data;
        end
      end
    end

    assign vld_vec[i] = vld_q;
    assign hit_vec[i] = vld_q && same_word(a_q[i], probe_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (ev_accept) wp_q <= bump(wp_q);
      if (ev_take)   rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CW'(ev_accept) - CW'(ev_take);
    end
  end

  // R3: occupancy counter agrees with the slot valid bits
  p_count_matches_slots_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_vec) == int'(cnt_q));

  // R3: never more than DEPTH entries
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);

  // R3: a dropped push (while full) leaves occupancy unchanged without a pop
  p_full_push_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);

endmodule

// File: rtl/mmio_rd_sched.sv
module mmio_rd_sched
  import mmio_ord_pkg::*;
#(
  parameter addr_t IO_BASE = 32'hFF00_0000,
  parameter addr_t IO_MASK = 32'hFF00_0000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_valid,
  input  addr_t rd_addr,
  input  logic  rd_exec,
  input  logic  q_empty,
  input  logic  q_hit,
  input  logic  io_decode_n,
  output logic  bus_rd_valid,
  output addr_t bus_rd_addr,
  output logic  io_inhibit_n,
  output logic  rd_done,
  output logic  hold_drain
);

  rd_state_e st_q, st_d;
  addr_t     addr_q;
  logic      inh_q, inh_d;

  // named internal events
  logic win_req, safe_now, may_issue, inh_issue;
  logic ev_issue, ev_cancel, ev_retry, in_cycle;

  assign win_req   = in_io_window(rd_addr, IO_BASE, IO_MASK);
  assign safe_now  = q_empty && rd_exec;
  assign may_issue = win_req ? safe_now : !q_hit;
  assign inh_issue = !win_req && !safe_now;

  assign in_cycle  = (st_q == RS_CYCLE);
  assign ev_issue  = (st_q == RS_IDLE) && rd_valid && may_issue;
  assign ev_retry  = (st_q == RS_RETRY) && safe_now;
  assign ev_cancel = in_cycle && inh_q && !io_decode_n;

  assign bus_rd_valid = in_cycle;
  assign bus_rd_addr  = addr_q;
  assign io_inhibit_n = !(in_cycle && inh_q);
  assign rd_done      = in_cycle && !ev_cancel;
  assign hold_drain   = in_cycle;

  always_comb begin
    st_d  = st_q;
    inh_d = inh_q;
    unique case (st_q)
      RS_IDLE: if (ev_issue) begin
        st_d  = RS_CYCLE;
        inh_d = inh_issue;
      end
      RS_CYCLE: st_d = ev_cancel ? RS_RETRY : RS_IDLE;
      RS_RETRY: if (ev_retry) begin
        st_d  = RS_CYCLE;
        inh_d = 1'b0;
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      inh_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q  <= st_d;
      inh_q <= inh_d;
      if (ev_issue) addr_q <= rd_addr;
    end
  end

  // R10: inhibit only accompanies a read bus cycle
  p_inhibit_in_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !io_inhibit_n |-> bus_rd_valid);

  // R4: a read cycle into the window is never inhibited
  p_window_uninhibited_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_valid && in_io_window(bus_rd_addr, IO_BASE, IO_MASK)) |-> io_inhibit_n);

  // R7: an inhibited cycle never comes out of the retry path
  p_retry_uninhibited_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_valid && !io_inhibit_n) |-> $past(st_q) == RS_IDLE);

  // R11: a bus cycle that completes lasts exactly one cycle
  p_single_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_valid && rd_done) |=> !bus_rd_valid);

endmodule

// File: rtl/mmio_order_unit.sv
module mmio_order_unit
  import mmio_ord_pkg::*;
#(
  parameter int    DATA_W  = 32,
  parameter int    QDEPTH  = 4,
  parameter addr_t IO_BASE = 32'hFF00_0000,
  parameter addr_t IO_MASK = 32'hFF00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [31:0]       wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              bus_wr_valid,
  output logic [31:0]       bus_wr_addr,
  output logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_wr_ready,
  input  logic              rd_valid,
  input  logic [31:0]       rd_addr,
  input  logic              rd_exec,
  output logic              rd_done,
  output logic              bus_rd_valid,
  output logic [31:0]       bus_rd_addr,
  output logic              io_inhibit_n,
  input  logic              io_decode_n
);

  logic q_full, q_empty, q_hit, hold_drain, ev_pop;

  assign wr_ready     = !q_full;
  assign bus_wr_valid = !q_empty && !hold_drain;
  assign ev_pop       = bus_wr_valid && bus_wr_ready;

  mmio_wr_queue #(.DATA_W(DATA_W), .DEPTH(QDEPTH)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (wr_valid),
    .push_addr  (wr_addr),
    .push_data  (wr_data),
    .pop        (ev_pop),
    .probe_addr (rd_addr),
    .full       (q_full),
    .empty      (q_empty),
    .probe_hit  (q_hit),
    .head_addr  (bus_wr_addr),
    .head_data  (bus_wr_data)
  );

  mmio_rd_sched #(.IO_BASE(IO_BASE), .IO_MASK(IO_MASK)) u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_valid     (rd_valid),
    .rd_addr      (rd_addr),
    .rd_exec      (rd_exec),
    .q_empty      (q_empty),
    .q_hit        (q_hit),
    .io_decode_n  (io_decode_n),
    .bus_rd_valid (bus_rd_valid),
    .bus_rd_addr  (bus_rd_addr),
    .io_inhibit_n (io_inhibit_n),
    .rd_done      (rd_done),
    .hold_drain   (hold_drain)
  );

  // R9: no write drains while a read cycle owns the bus
  p_no_drain_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_valid |-> !bus_wr_valid);

  // R4: an uninhibited window read follows an empty queue and an executing instruction
  p_window_safe_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_valid && io_inhibit_n && in_io_window(bus_rd_addr, IO_BASE, IO_MASK))
      |-> $past(q_empty && rd_exec));

  // R3: a stalled head write stays put unless a read cycle takes over
  p_head_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_valid && !bus_wr_ready && !wr_valid) |=>
      (bus_rd_valid || (bus_wr_valid && $stable(bus_wr_addr))));

endmodule

// File: tb/tb_mmio_order_unit.sv
module tb_mmio_order_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic        bus_wr_valid;
  logic [31:0] bus_wr_addr;
  logic [31:0] bus_wr_data;
  logic        bus_wr_ready = 1'b0;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        rd_exec = 1'b0;
  logic        rd_done;
  logic        bus_rd_valid;
  logic [31:0] bus_rd_addr;
  logic        io_inhibit_n;
  logic        io_decode_n = 1'b1;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int scen = 0;

  mmio_order_unit dut (.*);

  always #10 clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<=100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s scen=%0d act=%h exp=%h", req, scen, act, exp);
    end
  endtask

  function automatic logic [31:0] wa(int k);
    return 32'h1000_0000 + 32'(k * 16);
  endfunction

  function automatic logic [31:0] wd(int s, int k);
    return 32'hA000_0000 + 32'(s * 16 + k);
  endfunction

  // kind 0: window read, 1: outside window no match, 2: outside window matching write 0
  task automatic run(input int n, input int kind, input bit e, input bit d);
    bit issue, inh, done_seen, issued, cancelled;
    int drained;
    logic [31:0] ra;
    scen++;
    bus_wr_ready = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(wr_ready == 1'b1, "R3 ready below full", 32'(wr_ready), 1);
      wr_valid = 1'b1; wr_addr = wa(k); wr_data = wd(scen, k);
    end
    @(negedge clk);
    if (n == 4) begin
      wr_addr = 32'h3000_0000; wr_data = 32'hDEAD_BEEF;  // push offered while full
      @(negedge clk);
    end
    wr_valid = 1'b0;
    chk(wr_ready == (n < 4), "R3 ready vs fill", 32'(wr_ready), 32'(n < 4));

    ra = (kind == 0) ? 32'hFF00_0000 : (kind == 1) ? 32'hFEFF_FFFC : wa(0);
    rd_valid = 1'b1; rd_addr = ra; rd_exec = e; io_decode_n = d;
    // R2 classification decides the expected path
    issue = (kind == 0) ? (n == 0 && e) : (kind == 1);
    inh   = (kind != 0) && !(n == 0 && e);
    @(negedge clk);
    done_seen = 0; issued = 0; cancelled = 0; drained = 0;
    chk(bus_rd_valid == issue, (kind == 0) ? "R4 window issue" : (kind == 1) ? "R5 bypass issue" : "R6 match stall",
        32'(bus_rd_valid), 32'(issue));
    if (issue) begin
      issued = 1;
      chk(io_inhibit_n == !inh, "R5 inhibit at issue R11", 32'(io_inhibit_n), 32'(!inh));
      chk(bus_rd_addr == ra, "R11 bus address", bus_rd_addr, ra);
      if (inh && d) chk(rd_done == 1'b1, "R8 inhibited, not decoded, completes", 32'(rd_done), 1);
      else if (inh) chk(rd_done == 1'b0, "R7 decoded probe cancelled", 32'(rd_done), 0);
      else chk(rd_done == 1'b1, "R11 done in bus cycle", 32'(rd_done), 1);
      chk(!bus_wr_valid, "R9 no drain in read", 32'(bus_wr_valid), 0);
      cancelled = inh && !d;
      done_seen = rd_done;
    end
    rd_exec = 1'b1; bus_wr_ready = 1'b1;
    if (done_seen) rd_valid = 1'b0;
    if (bus_wr_valid) begin
      chk(bus_wr_addr == wa(drained) && bus_wr_data == wd(scen, drained), "R3 fifo order", bus_wr_addr, wa(drained));
      drained++;
    end
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      chk(io_inhibit_n || bus_rd_valid, "R10 inhibit outside read", 32'(io_inhibit_n), 1);
      if (bus_wr_valid) begin
        chk(bus_rd_valid == 1'b0, "R9 no drain in read", 32'(bus_rd_valid), 0);
        chk(drained < n, "R3 extra write drained", 32'(drained), 32'(n));
        chk(bus_wr_addr == wa(drained) && bus_wr_data == wd(scen, drained), "R3 fifo order", bus_wr_addr, wa(drained));
        drained++;
      end
      if (bus_rd_valid && !done_seen) begin
        if (!issued && kind == 2) chk(drained >= 1, "R6 issue after match drained", 32'(drained), 1);
        issued = 1;
        if (rd_done) begin
          done_seen = 1;
          rd_valid = 1'b0;
          if (!d) chk(io_inhibit_n == 1'b1, "R7 decoded read completes uninhibited", 32'(io_inhibit_n), 1);
          if (kind == 0 || cancelled) chk(drained == n, "R4 R7 completes after queue empty", 32'(drained), 32'(n));
        end
      end
    end
    chk(done_seen, "R11 read completed", 32'(done_seen), 1);
    chk(drained == n, "R3 all writes drained once, full push dropped", 32'(drained), 32'(n));
    io_decode_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R1 wr_ready", 32'(wr_ready), 1);
    chk(bus_wr_valid == 1'b0, "R1 bus_wr_valid", 32'(bus_wr_valid), 0);
    chk(bus_rd_valid == 1'b0, "R1 bus_rd_valid", 32'(bus_rd_valid), 0);
    chk(rd_done == 1'b0, "R1 rd_done", 32'(rd_done), 0);
    chk(io_inhibit_n == 1'b1, "R1 io_inhibit_n", 32'(io_inhibit_n), 1);
    for (int n = 0; n <= 4; n++)
      for (int kind = 0; kind < 3; kind++)
        for (int e = 0; e < 2; e++)
          for (int d = 0; d < 2; d++)
            if (!(kind == 2 && n == 0)) run(n, kind, e[0], d[0]);
    summary();
    $finish;
  end

endmodule